// File: doc/BRIEF.md
# Elapsed Seconds and Reference-Cycle Counters

This block keeps two free-running time counters in the 25 MHz reference clock domain. Both start from zero when the synchronous cold reset is held. The first output counts reference cycles within the current second. It is not updated every cycle. A 4-bit prescaler produces an update tick once every 16 reference cycles, which is 640 ns. On each tick the value advances by 16, so its four low bits never leave zero. When the value reaches the reference frequency (25,000,000 by default), it returns to zero, which happens exactly once per second. The second output counts whole elapsed seconds. It advances on the same clock edge at which the cycle value rolls over, and wraps naturally at the top of its width.

Both values are 32-bit read-only words for a neighbouring register bank. That bank owns any clock-domain crossing. There is no write or preset path.

The sub-second counter decides each cycle between three named update kinds, held in an enumerated type:
- STEP_HOLD: no tick this cycle; the value is kept.
- STEP_ADVANCE: a tick arrives below the limit; the value grows by 16.
- STEP_ROLLOVER: a tick arrives while the value is 16 below the limit; the value goes to zero and the seconds counter is told to advance.

Transitions:
- Any kind moves to STEP_HOLD when the prescaler is not at its last phase.
- STEP_HOLD moves to STEP_ADVANCE or STEP_ROLLOVER at the prescaler's last phase, chosen by the current value.

The reset drives the value to zero regardless of kind.

Top module: `elapsed_time_counters`

## Requirements
- R1: The cycle output changes only on the clock edge that ends a 16-cycle prescaler period (prescaler phase 15, phases counted 0 to 15 from reset release). It holds its value on the other 15 edges of each period.
- R2: Each change of the cycle output adds exactly 16, except at rollover, and bits 3:0 of the cycle output are always zero.
- R3: When an update is due while the cycle output equals REF_HZ-16, the cycle output becomes zero instead of REF_HZ.
- R4: The seconds output increases by one on exactly the edge where the cycle output rolls over to zero, and holds on every other edge.
- R5: While the synchronous active-high reset is sampled high, both outputs are zero on the following cycle. Counting restarts from zero after release.
- R6: The seconds counter is SEC_W bits wide and wraps from 2^SEC_W-1 to zero. It is zero-extended to 32 bits at the output.
- R7: After k rising edges with reset low, the cycle output equals (16*floor(k/16)) mod REF_HZ and the seconds output equals floor(k/REF_HZ) mod 2^SEC_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz reference clock |
| rst | input | 1 | Synchronous active-high cold reset |
| o_seconds | output | 32 | Whole seconds since the last reset, zero-extended from SEC_W bits |
| o_ref_cycles | output | 32 | Reference cycles within the current second, updated every 16 cycles |

## Verification
Both outputs are registered once after the prescaler, so the effect of the k-th edge after reset release shows up right after that edge. A cycle value of 16 first appears after edge 16, and the first second (rollover to zero together with seconds equal to one) appears after edge REF_HZ. The scoreboard tags every expected item with its edge count k and computes it from the R7 formula alone. The monitor compares at the falling edge that follows edge k, away from the active edge. The bench shrinks REF_HZ to 320 and SEC_W to 3, so that several rollovers and a seconds wrap fit in a short run. A reset applied mid-period is checked one cycle after it is sampled, and counting is then checked again from k equal to one.

// File: rtl/elapsed_time_pkg.sv
package elapsed_time_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        STEP_HOLD     = 2'd0,
        STEP_ADVANCE  = 2'd1,
        STEP_ROLLOVER = 2'd2
    } step_kind_e;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int unsigned PRESC_W = 4
) (
    input  logic clk,
    input  logic rst,
    output logic o_tick
);

    logic [PRESC_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_q + 1'b1;
    end

    assign o_tick = &phase_q;

    // R1: a tick never lasts two cycles, so updates are spaced apart
    assert_tick_single_R1: assert property (@(posedge clk) disable iff (rst)
        o_tick |=> !o_tick);

endmodule

// File: rtl/subsecond_counter.sv
module subsecond_counter
    import elapsed_time_pkg::*;
#(
    parameter int unsigned W     = 32,
    parameter int unsigned STEP  = 16,
    parameter int unsigned LIMIT = 25_000_000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         i_tick,
    output logic [W-1:0] o_value,
    output logic         o_wrap
);

    localparam logic [W-1:0] STEP_V = W'(STEP);
    localparam logic [W-1:0] LAST_V = W'(LIMIT - STEP);

    step_kind_e   kind;
    logic [W-1:0] value_q;

    // next-kind decision
    always_comb begin
        if (!i_tick)              kind = STEP_HOLD;
        else if (value_q == LAST_V) kind = STEP_ROLLOVER;
        else                      kind = STEP_ADVANCE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
        end else begin
            unique case (kind)
                STEP_HOLD:     value_q <= value_q;
                STEP_ADVANCE:  value_q <= value_q + STEP_V;
                STEP_ROLLOVER: value_q <= '0;
                default:       value_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        o_value = value_q;
        o_wrap  = (kind == STEP_ROLLOVER);
    end

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !i_tick |=> $stable(value_q));

    assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
        value_q[3:0] == 4'd0);

    assert_step_size_R2: assert property (@(posedge clk) disable iff (rst)
        (i_tick && value_q != LAST_V) |=> value_q == $past(value_q) + STEP_V);

    assert_rollover_R3: assert property (@(posedge clk) disable iff (rst)
        (i_tick && value_q == LAST_V) |=> value_q == '0);

endmodule

// File: rtl/seconds_counter.sv
module seconds_counter #(
    parameter int unsigned SEC_W = 32,
    parameter int unsigned W     = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         i_wrap,
    output logic [W-1:0] o_value
);

    logic [SEC_W-1:0] sec_q;

    always_ff @(posedge clk) begin
        if (rst)         sec_q <= '0;
        else if (i_wrap) sec_q <= sec_q + 1'b1;
    end

    assign o_value = W'(sec_q);

    assert_sec_advance_R4: assert property (@(posedge clk) disable iff (rst)
        i_wrap |=> sec_q == $past(sec_q) + 1'b1);

    assert_sec_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !i_wrap |=> $stable(sec_q));

    assert_sec_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (i_wrap && (&sec_q)) |=> sec_q == '0);

endmodule

// File: rtl/elapsed_time_counters.sv
module elapsed_time_counters
    import elapsed_time_pkg::*;
#(
    parameter int unsigned REF_HZ  = 25_000_000,
    parameter int unsigned PRESC_W = 4,
    parameter int unsigned SEC_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    output logic [WORD_W-1:0] o_seconds,
    output logic [WORD_W-1:0] o_ref_cycles
);

    localparam int unsigned STEP = 1 << PRESC_W;

    logic tick;
    logic wrap;

    tick_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .o_tick (tick)
    );

    subsecond_counter #(.W(WORD_W), .STEP(STEP), .LIMIT(REF_HZ)) u_frac (
        .clk     (clk),
        .rst     (rst),
        .i_tick  (tick),
        .o_value (o_ref_cycles),
        .o_wrap  (wrap)
    );

    seconds_counter #(.SEC_W(SEC_W), .W(WORD_W)) u_sec (
        .clk     (clk),
        .rst     (rst),
        .i_wrap  (wrap),
        .o_value (o_seconds)
    );

    // R5: reset clears both outputs on the following cycle
    assert_reset_clears_R5: assert property (@(posedge clk)
        rst |=> (o_seconds == '0 && o_ref_cycles == '0));

    // R4: seconds only move when the cycle value has just returned to zero
    assert_sec_with_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (o_seconds != $past(o_seconds)) |-> (o_ref_cycles == '0));

endmodule

// File: tb/sim_elapsed_time_counters.sv
module sim_elapsed_time_counters;

    localparam int CLK_PERIOD = 40;
    localparam int REF_HZ     = 320;
    localparam int SEC_W      = 3;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        int          k;
        logic [31:0] cyc;
        logic [31:0] sec;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] o_seconds;
    logic [31:0] o_ref_cycles;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    k_edges  = 0;
    int    cycles   = 0;
    bit    done     = 1'b0;
    item_t sb_q[$];

    elapsed_time_counters #(.REF_HZ(REF_HZ), .PRESC_W(4), .SEC_W(SEC_W)) u0 (
        .clk          (clk),
        .rst          (rst),
        .o_seconds    (o_seconds),
        .o_ref_cycles (o_ref_cycles)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // bench-side count of edges since reset release
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) k_edges <= 0;
        else     k_edges <= k_edges + 1;
    end

    function automatic string pick_req(int k);
        if (k > 0 && k % (REF_HZ * (1 << SEC_W)) == 0) return "R6";
        if (k > 0 && k % REF_HZ == 0)                   return "R3/R4";
        if (k % 16 == 0)                                return "R2";
        if (k % 16 != 15)                               return "R1";
        return "R7";
    endfunction

    task automatic push_run(input int from, input int to);
        for (int k = from; k <= to; k++) begin
            item_t it;
            it.k   = k;
            it.cyc = 32'(((k / 16) * 16) % REF_HZ);
            it.sec = 32'((k / REF_HZ) % (1 << SEC_W));
            it.req = pick_req(k);
            sb_q.push_back(it);
        end
    endtask

    task automatic report_summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // monitor: compare scoreboard head away from the active edge
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0 && sb_q[0].k == k_edges) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (o_ref_cycles !== it.cyc || o_seconds !== it.sec || o_ref_cycles[3:0] !== 4'd0) begin
                n_fail++;
                $display("FAIL %s k=%0d: cycles=%0d seconds=%0d expected cycles=%0d seconds=%0d",
                         it.req, it.k, o_ref_cycles, o_seconds, it.cyc, it.sec);
            end
        end
    end

    task automatic check_zero(input string tag);
        n_checks++;
        if (o_ref_cycles !== 32'd0 || o_seconds !== 32'd0) begin
            n_fail++;
            $display("FAIL %s reset: cycles=%0d seconds=%0d expected cycles=0 seconds=0",
                     tag, o_ref_cycles, o_seconds);
        end
    endtask

    // driver
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_zero("R5");
        // main run: several seconds and one seconds wrap (R6 at k=2560)
        push_run(1, 2600);
        rst = 1'b0;
        wait (sb_q.size() == 0);
        // reset in the middle of a prescaler period
        repeat (7) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_zero("R5");
        @(posedge clk);
        @(negedge clk);
        check_zero("R5");
        // R7: counting restarts from zero after release
        push_run(1, 700);
        rst = 1'b0;
        wait (sb_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        report_summary();
    end

    // watchdog
    always @(negedge clk) begin
        if (!done && cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected completion before %0d", cycles, WATCHDOG);
            done = 1'b1;
            report_summary();
        end
    end

endmodule